// File: doc/BRIEF.md
# Bank-Gated Memory Array

This block is a single-clock synchronous memory of 2048 words of 36 bits. The storage is cut by depth into four banks of 512 words each. On any access only the bank that holds the addressed word has its enable raised, and the other three stay idle. When no access is requested, no bank is enabled at all. Most of the storage therefore does not toggle on a given cycle, which keeps dynamic power low in a large array.

The two top address bits pick the bank, and the remaining nine bits pick the word inside it. Each bank has its own read register. A bank-select value is registered together with the read and drives a multiplexer that chooses which bank register reaches the output. A parameter sets how a write cycle affects the read port: in write-first mode the written word appears on the output, and in no-change mode the output keeps its previous value. A second parameter adds a register after the multiplexer. That register buys timing margin and costs one extra cycle of read latency. The one-hot bank-enable vector is brought out on a monitor port so that tests can observe it.

Top module: `bgm_array`

## Requirements
- R1: Every one of the 2048 word addresses holds its own 36-bit value. Address bits [10:9] select the bank and bits [8:0] select the word in that bank, so a write to one address never changes the value read from any other address.
- R2: When `accessEn` is 1, exactly one bit of `bankEnMon` is set, and it is bit number `addr[10:9]`.
- R3: When `accessEn` is 0, `bankEnMon` is all zero, whatever values `writeEn` and `addr` carry.
- R4: With `OUT_REG` = 0, a read accepted at clock edge k shows the stored word on `rdData` right after edge k.
- R5: With `OUT_REG` = 1, the read data reaches `rdData` one edge later than with `OUT_REG` = 0, that is right after edge k+1.
- R6: With `WRITE_FIRST` = 1, a write shows the newly written word on `rdData` with the same latency as a read.
- R7: With `WRITE_FIRST` = 0, a write leaves `rdData` unchanged.
- R8: `rdData` holds its last value across cycles with `accessEn` = 0.
- R9: While `rstN` is 0 at a clock edge (synchronous, active low), `rdData` is cleared to zero. The stored words are not cleared.
- R10: Back-to-back reads that hop between banks each return their own word, because the multiplexer follows the bank of the previous access and not the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| accessEn | input | 1 | Requests an access (read or write) this cycle |
| writeEn | input | 1 | 1 = write, 0 = read, when accessEn is 1 |
| addr | input | 11 | Word address; [10:9] bank, [8:0] word |
| wrData | input | 36 | Write data |
| rdData | output | 36 | Read data |
| bankEnMon | output | 4 | One-hot bank-enable vector, for observation |

## Verification
Two copies are driven by the same inputs. One runs write-first without the output register and the other runs no-change with it. Because the stimulus is shared, any difference between the copies can only come from the write-mode and latency settings. A full write sweep shows that every address stores its own word, and it also separates write-first from no-change behaviour on the output. Directed reads that hop between banks, idle gaps and a one-access-in-four pattern check the output multiplexer, the hold behaviour and the enable vector. A long random mix of reads, writes and idle cycles, compared against a model in the bench, catches aliasing between banks and stale-select errors.

// File: rtl/bgm_pkg.sv
package bgm_pkg;
  parameter int unsigned BANK_CNT = 4;
  localparam int unsigned SEL_W = $clog2(BANK_CNT);

  // strobes from control to datapath
  typedef struct packed {
    logic [BANK_CNT-1:0] bankEn;  // one-hot chip enables, zero when idle
    logic                wrEn;    // write strobe, qualified by bankEn
    logic [SEL_W-1:0]    selQ;    // registered bank select for the output mux
  } bankCtrl_t;
endpackage

// File: rtl/bgm_ctrl.sv
module bgm_ctrl
  import bgm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter bit          WRITE_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessEn,
  input  logic              writeEn,
  input  logic [ADDR_W-1:0] addr,
  output bankCtrl_t         ctrl
);
  logic [SEL_W-1:0]    bankSel;
  logic [BANK_CNT-1:0] bankEn;
  logic                loadSel;
  logic [SEL_W-1:0]    selQ;

  assign bankSel = addr[ADDR_W-1 -: SEL_W];

  always_comb begin
    bankEn = '0;
    if (accessEn) bankEn[bankSel] = 1'b1;
  end

  // select follows only accesses that refresh a bank read register
  assign loadSel = accessEn && (!writeEn || WRITE_FIRST);

  always_ff @(posedge clk) begin
    if (!rstN)        selQ <= '0;
    else if (loadSel) selQ <= bankSel;
  end

  assign ctrl.bankEn = bankEn;
  assign ctrl.wrEn   = accessEn && writeEn;
  assign ctrl.selQ   = selQ;

  p_bank_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    accessEn |-> (bankEn[addr[ADDR_W-1 -: SEL_W]] && $onehot0(bankEn)));

  p_idle_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !accessEn |-> (bankEn == '0));

  p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !accessEn |=> $stable(selQ));
endmodule

// File: rtl/bgm_datapath.sv
module bgm_datapath
  import bgm_pkg::*;
#(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned WORD_W      = 9,
  parameter bit          WRITE_FIRST = 1'b1,
  parameter bit          OUT_REG     = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankCtrl_t         ctrl,
  input  logic [WORD_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int unsigned DEPTH = 1 << WORD_W;

  logic [BANK_CNT-1:0][DATA_W-1:0] bankOut;
  logic [DATA_W-1:0]               muxOut;

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] dout;

    always_ff @(posedge clk) begin
      if (ctrl.bankEn[b] && ctrl.wrEn) mem[wordAddr] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dout <= '0;
      end else if (ctrl.bankEn[b]) begin
        if (!ctrl.wrEn)       dout <= mem[wordAddr];
        else if (WRITE_FIRST) dout <= wrData;
      end
    end

    assign bankOut[b] = dout;
  end

  assign muxOut = bankOut[ctrl.selQ];

  if (OUT_REG) begin : g_pipe
    logic [DATA_W-1:0] rdQ;
    always_ff @(posedge clk) begin
      if (!rstN) rdQ <= '0;
      else       rdQ <= muxOut;
    end
    assign rdData = rdQ;
  end else begin : g_direct
    assign rdData = muxOut;
  end

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.bankEn == '0) |=> $stable(muxOut));

  if (WRITE_FIRST) begin : g_chk_wf
    p_write_shows_r6: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.wrEn && (ctrl.bankEn != '0)) |=> (muxOut == $past(wrData)));
  end else begin : g_chk_nc
    p_write_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.wrEn && (ctrl.bankEn != '0)) |=> $stable(muxOut));
  end
endmodule

// File: rtl/bgm_array.sv
module bgm_array
  import bgm_pkg::*;
#(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned ADDR_W      = 11,
  parameter bit          WRITE_FIRST = 1'b1,
  parameter bit          OUT_REG     = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accessEn,
  input  logic                writeEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [BANK_CNT-1:0] bankEnMon
);
  localparam int unsigned WORD_W = ADDR_W - SEL_W;

  bankCtrl_t ctrl;

  bgm_ctrl #(.ADDR_W(ADDR_W), .WRITE_FIRST(WRITE_FIRST)) i_ctrl (
    .clk(clk), .rstN(rstN), .accessEn(accessEn), .writeEn(writeEn),
    .addr(addr), .ctrl(ctrl)
  );

  bgm_datapath #(.DATA_W(DATA_W), .WORD_W(WORD_W), .WRITE_FIRST(WRITE_FIRST),
                 .OUT_REG(OUT_REG)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wordAddr(addr[WORD_W-1:0]),
    .wrData(wrData), .rdData(rdData)
  );

  assign bankEnMon = ctrl.bankEn;
endmodule

// File: tb/test_bgm_array.sv
`timescale 1ns/1ps
module test_bgm_array;
  localparam int WATCHDOG_CYC = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accessEn = 1'b0;
  logic        writeEn = 1'b0;
  logic [10:0] addr = '0;
  logic [35:0] wrData = '0;
  logic [35:0] rdA, rdB;
  logic [3:0]  enA, enB;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [35:0] memModel [2048];
  logic [35:0] expA = '0, expBmid = '0, expB = '0;

  always #2 clk = ~clk;

  // write-first, no output register
  bgm_array #(.WRITE_FIRST(1'b1), .OUT_REG(1'b0)) i_bgm_array (
    .clk(clk), .rstN(rstN), .accessEn(accessEn), .writeEn(writeEn),
    .addr(addr), .wrData(wrData), .rdData(rdA), .bankEnMon(enA));

  // no-change, with output register
  bgm_array #(.WRITE_FIRST(1'b0), .OUT_REG(1'b1)) i_bgm_array_nc (
    .clk(clk), .rstN(rstN), .accessEn(accessEn), .writeEn(writeEn),
    .addr(addr), .wrData(wrData), .rdData(rdB), .bankEnMon(enB));

  function automatic logic [3:0] expMask(logic ae, logic [10:0] a);
    return ae ? (4'b0001 << a[10:9]) : 4'b0000;
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check enables, clock, update model, check outputs
  task automatic step(logic ae, logic we, logic [10:0] a, logic [35:0] d, string tag);
    logic [35:0] nextMid;
    accessEn = ae; writeEn = we; addr = a; wrData = d;
    #1;
    chk(ae ? "R2 enable A" : "R3 enable A", {32'd0, enA}, {32'd0, expMask(ae, a)});
    chk(ae ? "R2 enable B" : "R3 enable B", {32'd0, enB}, {32'd0, expMask(ae, a)});
    @(posedge clk);
    if (!rstN) begin
      expA = '0; expBmid = '0; expB = '0;
    end else begin
      nextMid = expBmid;
      if (ae && !we) nextMid = memModel[a];
      expB = expBmid;
      expBmid = nextMid;
      if (ae) expA = we ? d : memModel[a];
    end
    if (ae && we) memModel[a] = d;
    @(negedge clk);
    chk({tag, " rdData A"}, rdA, expA);
    chk({tag, " rdData B"}, rdB, expB);
  endtask

  initial begin
    void'($urandom(32'h5eed_0c4d));
    @(negedge clk);
    // R9: reset clears read data
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 11'(i * 600), 36'h0, "R9");
    rstN = 1'b1;

    // R6, R7, R1: fill every address
    for (int i = 0; i < 2048; i++)
      step(1'b1, 1'b1, 11'(i), {$urandom(), 4'(i)}, "R6,R7");

    // R10: reads hopping between banks
    step(1'b1, 1'b0, 11'd0,    '0, "R10");
    step(1'b1, 1'b0, 11'd512,  '0, "R10");
    step(1'b1, 1'b0, 11'd1024, '0, "R10");
    step(1'b1, 1'b0, 11'd1536, '0, "R10");
    step(1'b1, 1'b0, 11'd2047, '0, "R10");
    step(1'b1, 1'b0, 11'd511,  '0, "R4,R5");
    // R8: idle with moving address keeps output
    for (int i = 0; i < 4; i++) step(1'b0, i[0], 11'(i * 513), 36'hF_0F0F_0F0F, "R8");
    // R7: write in no-change mode after a read to another bank
    step(1'b1, 1'b0, 11'd700, '0, "R7");
    step(1'b1, 1'b1, 11'd1800, 36'hA_BCDE_1234, "R7");
    step(1'b0, 1'b0, 11'd0, '0, "R7");
    step(1'b1, 1'b0, 11'd1800, '0, "R1");
    // R3: one access every four cycles
    for (int i = 0; i < 40; i++)
      step(i % 4 == 0, 1'b0, 11'($urandom_range(0, 2047)), '0, "R3");

    // R1: random mix
    for (int i = 0; i < 3000; i++) begin
      logic ae, we;
      ae = ($urandom_range(0, 9) < 6);
      we = ($urandom_range(0, 9) < 3);
      step(ae, we, 11'($urandom_range(0, 2047)), {$urandom(), 4'($urandom())}, "R1");
    end

    // R9: reset mid-run clears output, memory kept
    rstN = 1'b0;
    step(1'b0, 1'b0, 11'd0, '0, "R9");
    rstN = 1'b1;
    step(1'b1, 1'b0, 11'd1800, '0, "R9");
    step(1'b0, 1'b0, 11'd0, '0, "R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule